// File: doc/BRIEF.md
# Pulse-by-Pulse Overcurrent Supervisor

This block sits between a PWM generator and the gate drivers of a six-switch bridge. Each switch has an active-low on-command and two digital comparator flags from the current sensing path: a warning flag for moderate overcurrent and a trip flag for a short circuit. The block passes each command to its gate output. When a switch's trip flag rises while that switch is commanded on, only that switch's gate is forced off, and a shared active-low fault line goes low. When the lower warning flag rises, a shared active-low warning line goes low and nothing is shut down.

Neither condition latches until reset. Each switch's blocked state and its share of both shared lines are cleared by that switch's next on-command, so protection works one PWM pulse at a time. All comparator and command inputs pass through two-flop synchronizers. A synchronous reset returns every switch to its idle state.

Every switch runs its own state machine with four states. IDLE means the command is off and nothing is latched. DRIVE means the command is on and the pulse is clean. LIMIT means a warning was seen in this pulse and the gate still follows the command. BLOCK means a trip was seen in this pulse and the gate is held off. The transitions are as follows:

- START: on the on-command edge, any state goes to BLOCK if the trip flag is present, else to LIMIT if the warning flag is present, else to DRIVE.
- RELEASE: DRIVE goes to IDLE when the command goes off.
- WARN: DRIVE goes to LIMIT on the warning flag.
- TRIP: DRIVE or LIMIT goes to BLOCK on the trip flag while the command is on.
- HOLD: LIMIT and BLOCK stay where they are, even after the command goes off, until the next START.

Top module: `pbp_ocp_supervisor`

## Requirements
- R1: While reset is asserted and on the cycle after it, all gate outputs are 0, fault_n is 1 and warn_n is 1.
- R2: With no comparator flag, gate[i] is 1 exactly while cmd_n[i] is 0. Bit i of every vector belongs to switch i.
- R3: A trip flag on an on-commanded switch forces that switch's gate to 0. Every other switch's gate keeps following its own command.
- R4: fault_n is 0 whenever at least one switch is in BLOCK, and 1 otherwise.
- R5: BLOCK, and the low fault_n it causes, persist after the command goes off. Both are cleared by that switch's next on-command (a 1-to-0 change of cmd_n[i]) if the trip flag is absent at that edge.
- R6: A warning flag on an on-commanded switch drives warn_n to 0 and leaves that switch's gate following its command.
- R7: The warning persists after the command goes off. It is cleared by that switch's next on-command if the warning flag is absent at that edge.
- R8: Trip and warning flags that arrive while a switch's command is off have no effect on its gate, fault_n or warn_n.
- R9: A trip flag during LIMIT moves the switch to BLOCK, so fault_n goes to 0 and that switch's share of warn_n is released. A trip flag present at the on-command edge blocks that pulse from its start.
- R10: An input change reaches the outputs on the third rising clock edge after it is applied: two synchronizer stages, then the state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_n | input | N_SW | Active-low on-commands, one per switch |
| sc_hit | input | N_SW | Short-circuit comparator flags, active high |
| warn_hit | input | N_SW | Overcurrent-warning comparator flags, active high |
| gate_on | output | N_SW | Gate drive enables, active high |
| fault_n | output | 1 | Shared short-circuit fault, active low |
| warn_n | output | 1 | Shared current-limit warning, active low |

## Verification
The bench targets these cases:

- Command off after a trip. A design that cleared BLOCK when the command went off would release fault_n one pulse early.
- Trip flag held across an on-command edge. A design that re-armed unconditionally would let the gate conduct into a short for a cycle.
- Comparator flags raised while every command is off. A careless design would latch faults it should ignore.
- A trip arriving on top of a warning. A design that mishandled this would either miss the block or keep both shared lines low.

Random stimulus with sparse command toggles and brief flag pulses mixes these cases across all six switches. It also confirms that a block on one switch never disturbs its neighbours' gates.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_DRIVE = 2'd1,
        SW_LIMIT = 2'd2,
        SW_BLOCK = 2'd3
    } sw_state_e;

endpackage

// File: rtl/pbp_sync.sv
// Two-stage synchronizer for a bundle of asynchronous level inputs.
module pbp_sync #(
    parameter int W       = 6,
    parameter bit RST_BIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    localparam logic [W-1:0] RST_VEC = {W{RST_BIT}};

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VEC;
            d_out  <= RST_VEC;
        end else begin
            stage1 <= d_in;
            d_out  <= stage1;
        end
    end
endmodule

// File: rtl/pbp_switch_fsm.sv
// Per-switch pulse-by-pulse protection state machine.
module pbp_switch_fsm
    import pbp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_on,
    input  logic sc_hit,
    input  logic warn_hit,
    output logic gate_on,
    output logic trip,
    output logic limit,
    output logic on_edge
);
    sw_state_e state, nxt, start_state;
    logic      cmd_q;

    // previous synchronized command, for on-edge detection
    always_ff @(posedge clk) begin
        if (rst) cmd_q <= 1'b0;
        else     cmd_q <= cmd_on;
    end

    assign on_edge = cmd_on & ~cmd_q;

    // state a fresh pulse begins in (START)
    always_comb begin
        if (sc_hit)        start_state = SW_BLOCK;
        else if (warn_hit) start_state = SW_LIMIT;
        else               start_state = SW_DRIVE;
    end

    always_comb begin
        nxt = state;
        if (on_edge) begin
            nxt = start_state;
        end else begin
            unique case (state)
                SW_IDLE:  nxt = SW_IDLE;
                SW_DRIVE: begin
                    if (!cmd_on)       nxt = SW_IDLE;
                    else if (sc_hit)   nxt = SW_BLOCK;
                    else if (warn_hit) nxt = SW_LIMIT;
                end
                SW_LIMIT: begin
                    if (cmd_on && sc_hit) nxt = SW_BLOCK;
                end
                SW_BLOCK: nxt = SW_BLOCK;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= SW_IDLE;
        else     state <= nxt;
    end

    // registered gate output, aligned with the state register
    always_ff @(posedge clk) begin
        if (rst) gate_on <= 1'b0;
        else     gate_on <= cmd_on & (nxt != SW_BLOCK);
    end

    always_comb begin
        trip  = (state == SW_BLOCK);
        limit = (state == SW_LIMIT);
    end
endmodule

// File: rtl/pbp_flag_merge.sv
// Combines per-switch states into the shared active-low lines.
module pbp_flag_merge #(
    parameter int N_SW = 6
) (
    input  logic [N_SW-1:0] trip,
    input  logic [N_SW-1:0] limit,
    output logic            fault_n,
    output logic            warn_n
);
    always_comb begin
        fault_n = ~(|trip);
        warn_n  = ~(|limit);
    end
endmodule

// File: rtl/pbp_ocp_supervisor.sv
module pbp_ocp_supervisor #(
    parameter int N_SW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_SW-1:0] cmd_n,
    input  logic [N_SW-1:0] sc_hit,
    input  logic [N_SW-1:0] warn_hit,
    output logic [N_SW-1:0] gate_on,
    output logic            fault_n,
    output logic            warn_n
);
    logic [N_SW-1:0] cmd_n_s, cmd_on_s, sc_s, warn_s;
    logic [N_SW-1:0] trip_v, lim_v, edge_v;

    pbp_sync #(.W(N_SW), .RST_BIT(1'b1)) u_sync_cmd (
        .clk(clk), .rst(rst), .d_in(cmd_n), .d_out(cmd_n_s)
    );
    pbp_sync #(.W(N_SW), .RST_BIT(1'b0)) u_sync_sc (
        .clk(clk), .rst(rst), .d_in(sc_hit), .d_out(sc_s)
    );
    pbp_sync #(.W(N_SW), .RST_BIT(1'b0)) u_sync_warn (
        .clk(clk), .rst(rst), .d_in(warn_hit), .d_out(warn_s)
    );

    assign cmd_on_s = ~cmd_n_s;

    for (genvar i = 0; i < N_SW; i++) begin : g_sw
        pbp_switch_fsm u_fsm (
            .clk      (clk),
            .rst      (rst),
            .cmd_on   (cmd_on_s[i]),
            .sc_hit   (sc_s[i]),
            .warn_hit (warn_s[i]),
            .gate_on  (gate_on[i]),
            .trip     (trip_v[i]),
            .limit    (lim_v[i]),
            .on_edge  (edge_v[i])
        );
    end

    pbp_flag_merge #(.N_SW(N_SW)) u_merge (
        .trip(trip_v), .limit(lim_v), .fault_n(fault_n), .warn_n(warn_n)
    );
endmodule

// File: rtl/pbp_ocp_checker.sv
module pbp_ocp_checker #(
    parameter int N_SW = 6
) (
    input logic            clk,
    input logic            rst,
    input logic [N_SW-1:0] gate,
    input logic            fault_n,
    input logic            warn_n,
    input logic [N_SW-1:0] cmd_on_s,
    input logic [N_SW-1:0] sc_s,
    input logic [N_SW-1:0] trip,
    input logic [N_SW-1:0] limit,
    input logic [N_SW-1:0] on_edge
);
    for (genvar i = 0; i < N_SW; i++) begin : g_chk
        p_blocked_gate_low_r3: assert property (@(posedge clk) disable iff (rst)
            trip[i] |-> !gate[i]);
        p_trip_cause_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(trip[i]) |-> $past(sc_s[i]));
        p_block_persists_r5: assert property (@(posedge clk) disable iff (rst)
            (trip[i] && !on_edge[i]) |=> trip[i]);
        p_limit_gate_follows_r6: assert property (@(posedge clk) disable iff (rst)
            (limit[i] && $past(cmd_on_s[i])) |-> gate[i]);
        p_limit_persists_r7: assert property (@(posedge clk) disable iff (rst)
            (limit[i] && !on_edge[i] && !sc_s[i]) |=> limit[i]);
        p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
            (!cmd_on_s[i] && !trip[i] && !limit[i]) |=> (!trip[i] && !limit[i]));
    end

    p_fault_with_block_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n) |-> (|trip));
endmodule

bind pbp_ocp_supervisor pbp_ocp_checker #(.N_SW(N_SW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .gate     (gate_on),
    .fault_n  (fault_n),
    .warn_n   (warn_n),
    .cmd_on_s (cmd_on_s),
    .sc_s     (sc_s),
    .trip     (trip_v),
    .limit    (lim_v),
    .on_edge  (edge_v)
);

// File: tb/sim_pbp_ocp_supervisor.sv
module sim_pbp_ocp_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] cmd_n = '1;
    logic [N-1:0] sc_hit = '0;
    logic [N-1:0] warn_hit = '0;
    logic [N-1:0] gate_on;
    logic         fault_n, warn_n;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // expected-value model state (0 idle, 1 drive, 2 limit, 3 block)
    int           m_st [N];
    logic [N-1:0] m_gate = '0;
    logic [N-1:0] m_d1c = '0, m_d2c = '0, m_pc = '0;
    logic [N-1:0] m_d1s = '0, m_d2s = '0, m_d1w = '0, m_d2w = '0;

    pbp_ocp_supervisor #(.N_SW(N)) u0 (
        .clk(clk), .rst(rst), .cmd_n(cmd_n), .sc_hit(sc_hit),
        .warn_hit(warn_hit), .gate_on(gate_on), .fault_n(fault_n), .warn_n(warn_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int next_st(int st, logic c, logic cp, logic s, logic w);
        if (c && !cp) return s ? 3 : (w ? 2 : 1);
        case (st)
            1: begin
                if (!c) return 0;
                if (s)  return 3;
                if (w)  return 2;
                return 1;
            end
            2: return (c && s) ? 3 : 2;
            3: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic exp_fault_n();
        for (int i = 0; i < N; i++) if (m_st[i] == 3) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic exp_warn_n();
        for (int i = 0; i < N; i++) if (m_st[i] == 2) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // one cycle: compare at negedge, drive new inputs, advance the model
    task automatic step(logic r, logic [N-1:0] cn, logic [N-1:0] s, logic [N-1:0] w);
        @(negedge clk);
        chk(phase, "gate_on", gate_on, m_gate);
        chk(phase, "fault_n", {{(N-1){1'b0}}, fault_n}, {{(N-1){1'b0}}, exp_fault_n()});
        chk(phase, "warn_n",  {{(N-1){1'b0}}, warn_n},  {{(N-1){1'b0}}, exp_warn_n()});
        rst = r; cmd_n = cn; sc_hit = s; warn_hit = w;
        if (r) begin
            for (int i = 0; i < N; i++) m_st[i] = 0;
            m_gate = '0; m_pc = '0;
            m_d1c = '0; m_d2c = '0; m_d1s = '0; m_d2s = '0; m_d1w = '0; m_d2w = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                int ns;
                ns = next_st(m_st[i], m_d2c[i], m_pc[i], m_d2s[i], m_d2w[i]);
                m_gate[i] = m_d2c[i] && (ns != 3);
                m_st[i] = ns;
            end
            m_pc = m_d2c;
            m_d2c = m_d1c; m_d2s = m_d1s; m_d2w = m_d1w;
            m_d1c = ~cn;   m_d1s = s;     m_d1w = w;
        end
    endtask

    task automatic hold(int n, logic [N-1:0] cn, logic [N-1:0] s, logic [N-1:0] w);
        for (int k = 0; k < n; k++) step(1'b0, cn, s, w);
    endtask

    initial begin
        for (int i = 0; i < N; i++) m_st[i] = 0;
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] rc, rs, rw;
        void'($urandom(32'd20240611));

        // R1: reset state
        phase = "R1";
        for (int k = 0; k < 3; k++) step(1'b1, '1, '0, '0);
        step(1'b0, '1, '0, '0);
        chk("R1", "gate_on", gate_on, '0);
        chk("R1", "flags", {4'b0, fault_n, warn_n}, 6'b000011);

        // R10 and R2: latency of three edges, gate follows command
        phase = "R10";
        step(1'b0, 6'b111110, '0, '0);
        step(1'b0, 6'b111110, '0, '0);
        chk("R10", "gate early 1", gate_on, '0);
        step(1'b0, 6'b111110, '0, '0);
        chk("R10", "gate early 2", gate_on, '0);
        step(1'b0, 6'b111110, '0, '0);
        chk("R10", "gate on", gate_on, 6'b000001);
        phase = "R2";
        hold(4, 6'b010101, '0, '0);
        chk("R2", "gate pattern", gate_on, 6'b101010);

        // R3, R4: trip isolates one switch
        phase = "R3";
        hold(4, '0, '0, '0);
        step(1'b0, '0, 6'b000100, '0);
        hold(3, '0, '0, '0);
        chk("R3", "gate isolation", gate_on, 6'b111011);
        chk("R4", "fault_n", {5'b0, fault_n}, 6'b0);

        // R5: block persists through off, clears on next on-edge
        phase = "R5";
        hold(4, 6'b000100, '0, '0);
        chk("R5", "fault kept", {5'b0, fault_n}, 6'b0);
        hold(4, '0, '0, '0);
        chk("R5", "fault cleared", {5'b0, fault_n}, 6'b000001);
        chk("R5", "gate restored", gate_on, 6'b111111);

        // R6, R7: warning without shutdown, cleared pulse by pulse
        phase = "R6";
        step(1'b0, '0, '0, 6'b010000);
        hold(3, '0, '0, '0);
        chk("R6", "warn_n", {5'b0, warn_n}, 6'b0);
        chk("R6", "gate kept", gate_on, 6'b111111);
        phase = "R7";
        hold(4, 6'b010000, '0, '0);
        chk("R7", "warn kept", {5'b0, warn_n}, 6'b0);
        hold(4, '0, '0, '0);
        chk("R7", "warn cleared", {5'b0, warn_n}, 6'b000001);

        // R8: flags while commands are off
        phase = "R8";
        hold(4, '1, '0, '0);
        hold(2, '1, '1, '1);
        hold(4, '1, '0, '0);
        chk("R8", "flags", {4'b0, fault_n, warn_n}, 6'b000011);
        chk("R8", "gate", gate_on, '0);

        // R9: escalation and trip present at the edge
        phase = "R9";
        hold(4, 6'b111101, '0, '0);
        step(1'b0, 6'b111101, '0, 6'b000010);
        hold(3, 6'b111101, '0, '0);
        chk("R9", "warn", {4'b0, fault_n, warn_n}, 6'b000010);
        step(1'b0, 6'b111101, 6'b000010, '0);
        hold(3, 6'b111101, '0, '0);
        chk("R9", "escalated", {4'b0, fault_n, warn_n}, 6'b000001);
        hold(4, '1, 6'b000010, '0);
        hold(4, 6'b111101, 6'b000010, '0);
        chk("R9", "blocked at edge", gate_on, '0);
        hold(4, 6'b111101, '0, '0);
        chk("R9", "still blocked", {5'b0, fault_n}, 6'b0);
        hold(4, '1, '0, '0);
        hold(4, 6'b111101, '0, '0);
        chk("R9", "released", gate_on, 6'b000010);

        // random mix across all switches
        phase = "R2 R3 R4 R5 R6 R7 R8 R9 random";
        rc = '1;
        for (int k = 0; k < 4000; k++) begin
            rs = '0; rw = '0;
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(0, 11) == 0) rc[i] = ~rc[i];
                if ($urandom_range(0, 39) == 0) rs[i] = 1'b1;
                if ($urandom_range(0, 9) == 0)  rw[i] = 1'b1;
            end
            step(($urandom_range(0, 999) == 0), rc, rs, rw);
        end
        step(1'b0, '1, '0, '0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule